// File: doc/BRIEF.md
# Reciprocal-Multiply Coefficient Quantizer

This block quantizes one signed transform coefficient per clock for an image compression pipeline. It multiplies the coefficient by a reciprocal of the quantization step instead of dividing by it. The caller supplies the reciprocal as a 16-bit word equal to round(2^15 / Q). The block takes the magnitude of the coefficient and multiplies it by the reciprocal. It then scales the product back by 2^15 with round-to-nearest and restores the sign. A valid strobe travels with each sample, and the matching output enable appears a fixed four cycles later.

The multiply is broken into two narrow partial products that are registered side by side. A separate stage then adds them into the full-width product. This keeps the longest register-to-register path close to that of one narrow multiplier. Samples may arrive back to back or with gaps. Each sample brings its own reciprocal, so the step size may change on every cycle. Building and storing reciprocals belong to the surrounding logic.

Top module: `recip_quantizer`

## Requirements
- R1: While reset (rstN low) is asserted and in the first cycle after it, outEn is 0 and qOut is 0.
- R2: outEn is 1 exactly four rising edges after the edge that sampled inStrobe high, and 0 in every other cycle. Back-to-back strobes give back-to-back enables at one result per cycle.
- R3: For a sample with coefficient c (two's complement, 11 bits) and reciprocal r (unsigned, 16 bits), the result magnitude is m = floor((|c|*r + 2^14) / 2^15). The result is +m for c >= 0 and -m in two's complement for c < 0.
- R4: A magnitude above 1023 saturates to 1023. The output range is -1023..+1023, and the code -1024 (binary 100_0000_0000) never appears, including for c = -1024.
- R5: A zero coefficient gives a zero result for any reciprocal value.
- R6: When outEn is 0, qOut keeps the value of the last valid result. Inputs presented with inStrobe low do not change qOut.
- R7: With r = round(2^15/Q) and Q from 1 to 255, the result differs by at most 1 from c/Q rounded to nearest with halves away from zero.
- R8: The reciprocal is captured together with its coefficient. When a different reciprocal arrives on every cycle, each result is the one R3 gives for its own reciprocal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inStrobe | input | 1 | Marks coefIn and recipIn as a valid sample |
| coefIn | input | 11 | Signed coefficient |
| recipIn | input | 16 | Unsigned reciprocal, round(2^15/Q) |
| outEn | output | 1 | Marks qOut as a new result |
| qOut | output | 11 | Signed quantized result |

## Verification
The bench builds the block with its default parameters: 11-bit coefficients, a 16-bit reciprocal, a 15-bit scale and the split multiplier. With these values the full coefficient range is reachable, including -1024, whose magnitude needs all eleven unsigned bits. They also reach Q = 1 with a reciprocal of exactly 2^15, and reciprocals above 2^15 that drive the magnitude past 1023 into saturation. Back-to-back, gapped and single-pulse strobe patterns expose the four-cycle alignment, and a new reciprocal on every sample shows that each step size stays attached to its own coefficient.

// File: rtl/quant_pkg.sv
package quant_pkg;
  // Per-stage load enables handed from control to datapath
  typedef struct packed {
    logic s1En;
    logic s2aEn;
    logic s2bEn;
    logic s3En;
  } stage_en_t;
endpackage

// File: rtl/quant_ctrl.sv
module quant_ctrl
  import quant_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inStrobe,
  output stage_en_t stageEn,
  output logic      outEn
);
  localparam int CNT_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], inStrobe};
  end

  always_comb begin
    stageEn.s1En  = inStrobe;
    stageEn.s2aEn = validPipe[0];
    stageEn.s2bEn = validPipe[1];
    stageEn.s3En  = validPipe[2];
  end

  assign outEn = validPipe[STAGES-1];

  // Edges since reset release, saturating, for the latency check
  logic [CNT_W-1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != CNT_W'(STAGES)) sinceRst <= sinceRst + 1'b1;
  end

  // R2: enable trails the strobe by four edges
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CNT_W'(STAGES)) |-> (outEn == $past(inStrobe, 4)));

  // R1: first cycle out of reset carries no enable
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !outEn);
endmodule

// File: rtl/quant_datapath.sv
module quant_datapath
  import quant_pkg::*;
#(
  parameter int COEF_W    = 11,
  parameter int RECIP_W   = 16,
  parameter int FRAC_W    = 15,
  parameter bit SPLIT_MUL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_en_t         stageEn,
  input  logic [COEF_W-1:0] coefIn,
  input  logic [RECIP_W-1:0] recipIn,
  output logic [COEF_W-1:0] qOut
);
  localparam int PROD_W  = COEF_W + RECIP_W;
  localparam int LO_W    = RECIP_W / 2;
  localparam int HI_W    = RECIP_W - LO_W;
  localparam int RND_W   = PROD_W - FRAC_W + 1;
  localparam int MAX_MAG = 2 ** (COEF_W - 1) - 1;

  // Stage 1: sign, magnitude, reciprocal capture
  logic               signS1;
  logic [COEF_W-1:0]  absS1;
  logic [RECIP_W-1:0] recipS1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signS1  <= 1'b0;
      absS1   <= '0;
      recipS1 <= '0;
    end else if (stageEn.s1En) begin
      signS1  <= coefIn[COEF_W-1];
      absS1   <= coefIn[COEF_W-1] ? (~coefIn + 1'b1) : coefIn;
      recipS1 <= recipIn;
    end
  end

  // Stage 2a: multiply (split or wide), Stage 2b: full product
  logic              signS2;
  logic [PROD_W-1:0] sumNext;

  always_ff @(posedge clk) begin
    if (!rstN)              signS2 <= 1'b0;
    else if (stageEn.s2aEn) signS2 <= signS1;
  end

  generate
    if (SPLIT_MUL) begin : gSplit
      logic [COEF_W+HI_W-1:0] hiS2;
      logic [COEF_W+LO_W-1:0] loS2;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          hiS2 <= '0;
          loS2 <= '0;
        end else if (stageEn.s2aEn) begin
          hiS2 <= {{HI_W{1'b0}}, absS1} * {{COEF_W{1'b0}}, recipS1[RECIP_W-1:LO_W]};
          loS2 <= {{LO_W{1'b0}}, absS1} * {{COEF_W{1'b0}}, recipS1[LO_W-1:0]};
        end
      end
      assign sumNext = {hiS2, {LO_W{1'b0}}} + {{HI_W{1'b0}}, loS2};
    end else begin : gWide
      logic [PROD_W-1:0] wideS2;
      always_ff @(posedge clk) begin
        if (!rstN)              wideS2 <= '0;
        else if (stageEn.s2aEn) wideS2 <= {{RECIP_W{1'b0}}, absS1} * {{COEF_W{1'b0}}, recipS1};
      end
      assign sumNext = wideS2;
    end
  endgenerate

  logic              signS3;
  logic [PROD_W-1:0] prodS3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signS3 <= 1'b0;
      prodS3 <= '0;
    end else if (stageEn.s2bEn) begin
      signS3 <= signS2;
      prodS3 <= sumNext;
    end
  end

  // Stage 3: round, saturate, restore sign
  logic [RND_W-1:0]  roundMag;
  logic [COEF_W-1:0] satMag;
  logic [COEF_W-1:0] qNext;

  always_comb begin
    roundMag = {1'b0, prodS3[PROD_W-1:FRAC_W]} + {{(RND_W-1){1'b0}}, prodS3[FRAC_W-1]};
    satMag   = (roundMag > RND_W'(MAX_MAG)) ? COEF_W'(MAX_MAG) : roundMag[COEF_W-1:0];
    qNext    = signS3 ? (~satMag + 1'b1) : satMag;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             qOut <= '0;
    else if (stageEn.s3En) qOut <= qNext;
  end

  // R6: no stage-3 load, no change at the output
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stageEn.s3En |=> $stable(qOut));

  // R4: most negative code is never produced
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    stageEn.s3En |=> (qOut != {1'b1, {(COEF_W-1){1'b0}}}));

  // R5: zero product gives zero output regardless of sign
  assert_zero_out_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stageEn.s3En && prodS3 == '0) |=> (qOut == '0));

  // R3: positive samples never come out negative
  assert_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stageEn.s3En && !signS3) |=> !qOut[COEF_W-1]);
endmodule

// File: rtl/recip_quantizer.sv
module recip_quantizer
  import quant_pkg::*;
#(
  parameter int COEF_W    = 11,
  parameter int RECIP_W   = 16,
  parameter int FRAC_W    = 15,
  parameter bit SPLIT_MUL = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inStrobe,
  input  logic [COEF_W-1:0]  coefIn,
  input  logic [RECIP_W-1:0] recipIn,
  output logic               outEn,
  output logic [COEF_W-1:0]  qOut
);
  localparam int STAGES = 4;

  stage_en_t stageEn;

  quant_ctrl #(.STAGES(STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inStrobe(inStrobe),
    .stageEn (stageEn),
    .outEn   (outEn)
  );

  quant_datapath #(
    .COEF_W   (COEF_W),
    .RECIP_W  (RECIP_W),
    .FRAC_W   (FRAC_W),
    .SPLIT_MUL(SPLIT_MUL)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stageEn(stageEn),
    .coefIn (coefIn),
    .recipIn(recipIn),
    .qOut   (qOut)
  );
endmodule

// File: tb/tb_recip_quantizer.sv
module tb_recip_quantizer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inStrobe = 1'b0;
  logic [10:0] coefIn = '0;
  logic [15:0] recipIn = '0;
  logic        outEn;
  logic [10:0] qOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;

  recip_quantizer dut (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .coefIn(coefIn),
    .recipIn(recipIn), .outEn(outEn), .qOut(qOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Four-deep expectation pipe
  logic        expEn[4];
  int          expVal[4];
  bit          expHasTrue[4];
  int          expTrue[4];
  string       expTag[4];
  int          lastOut = 0;

  function automatic int modelQ(int c, int r);
    longint mag, m;
    mag = (c < 0) ? -c : c;
    m = (mag * r + 16384) >> 15;
    if (m > 1023) m = 1023;
    return (c < 0) ? -int'(m) : int'(m);
  endfunction

  function automatic int recipOf(int q);
    return (65536 + q) / (2 * q);
  endfunction

  function automatic int trueRound(int c, int q);
    int mag, m;
    mag = (c < 0) ? -c : c;
    m = (2 * mag + q) / (2 * q);
    return (c < 0) ? -m : m;
  endfunction

  function automatic int toSigned(logic [10:0] v);
    return v[10] ? int'(v) - 2048 : int'(v);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One cycle: check the sample from four steps ago, then drive a new one
  task automatic step(bit stb, int c, int r, bit hasQ, int q, string tag);
    int act, diff;
    @(negedge clk);
    act = toSigned(qOut);
    if (expEn[3]) begin
      check(outEn == 1'b1, {"R2 enable ", expTag[3]}, int'(outEn), 1);
      check(act == expVal[3], {"R3 value ", expTag[3]}, act, expVal[3]);
      if (expHasTrue[3]) begin
        diff = act - expTrue[3];
        check(diff >= -1 && diff <= 1, {"R7 vs division ", expTag[3]}, act, expTrue[3]);
      end
      lastOut = expVal[3];
    end else begin
      check(outEn == 1'b0, "R2 idle enable", int'(outEn), 0);
      check(act == lastOut, "R6 hold", act, lastOut);
    end
    for (int i = 3; i > 0; i--) begin
      expEn[i] = expEn[i-1]; expVal[i] = expVal[i-1];
      expHasTrue[i] = expHasTrue[i-1]; expTrue[i] = expTrue[i-1];
      expTag[i] = expTag[i-1];
    end
    expEn[0] = stb;
    expVal[0] = modelQ(c, r);
    expHasTrue[0] = hasQ;
    expTrue[0] = hasQ ? trueRound(c, q) : 0;
    expTag[0] = tag;
    inStrobe = stb;
    coefIn = 11'(c);
    recipIn = 16'(r);
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 1'b0, 1, "drain");
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) expEn[i] = 1'b0;
    rstN = 1'b0;
    inStrobe = 1'b1; coefIn = 11'd500; recipIn = 16'd32768;
    repeat (3) @(negedge clk);
    check(outEn == 1'b0, "R1 reset enable", int'(outEn), 0);
    check(qOut == '0, "R1 reset value", toSigned(qOut), 0);
    inStrobe = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(outEn == 1'b0, "R1 post-reset enable", int'(outEn), 0);
    check(qOut == '0, "R1 post-reset value", toSigned(qOut), 0);
  endtask

  task automatic testCorners();
    step(1'b1, 1023, recipOf(1), 1'b1, 1, "R3 +1023 Q=1");
    step(1'b1, -1023, recipOf(1), 1'b1, 1, "R3 -1023 Q=1");
    step(1'b1, -1024, recipOf(1), 1'b1, 1, "R4 -1024 Q=1");
    step(1'b1, 1, 16384, 1'b0, 1, "R3 round up half");
    step(1'b1, 1, 16383, 1'b0, 1, "R3 below half");
    step(1'b1, -1, 16384, 1'b0, 1, "R3 negative half");
    step(1'b1, 1023, recipOf(255), 1'b1, 255, "R7 +1023 Q=255");
    step(1'b1, -1023, recipOf(255), 1'b1, 255, "R7 -1023 Q=255");
    drain();
  endtask

  task automatic testSaturation();
    step(1'b1, 600, 16'hFFFF, 1'b0, 1, "R4 positive saturate");
    step(1'b1, -600, 16'hFFFF, 1'b0, 1, "R4 negative saturate");
    step(1'b1, -1024, 16'hFFFF, 1'b0, 1, "R4 -1024 max recip");
    step(1'b1, 1023, 16'hFFFF, 1'b0, 1, "R4 +1023 max recip");
    drain();
  endtask

  task automatic testZero();
    step(1'b1, 0, 16'hFFFF, 1'b0, 1, "R5 zero max recip");
    step(1'b1, 0, 0, 1'b0, 1, "R5 zero zero recip");
    step(1'b1, 0, recipOf(1), 1'b1, 1, "R5 zero Q=1");
    drain();
  endtask

  task automatic testGaps();
    step(1'b1, 777, recipOf(3), 1'b1, 3, "R6 before gap");
    for (int i = 0; i < 6; i++)
      step(1'b0, -900 + i * 37, 16'hFFFF, 1'b0, 1, "R6 ignored");
    step(1'b1, -345, recipOf(7), 1'b1, 7, "R2 single pulse");
    step(1'b0, 100, 1000, 1'b0, 1, "R6 ignored");
    step(1'b1, 222, recipOf(9), 1'b1, 9, "R2 after gap");
    drain();
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      int q, c;
      q = int'($urandom_range(255, 1));
      c = int'($urandom_range(2047, 0)) - 1024;
      step(1'b1, c, recipOf(q), 1'b1, q, "R8 per-sample Q random");
    end
    for (int i = 0; i < 200; i++) begin
      int q, c;
      bit s;
      q = int'($urandom_range(255, 1));
      c = int'($urandom_range(2047, 0)) - 1024;
      s = 1'($urandom_range(1, 0));
      step(s, c, recipOf(q), 1'b1, q, "R7 random gapped");
    end
    drain();
  endtask

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end

  initial begin
    testReset();
    testCorners();
    testSaturation();
    testZero();
    testGaps();
    testRandom();
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end
endmodule